// File: doc/BRIEF.md
# Multicycle 32-bit Integer Datapath

This block is the datapath half of a small multicycle processor. It executes a reduced integer instruction set: word load and store, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), branch-if-equal and absolute jump. A single memory port serves both instruction and data accesses. A single ALU is reused in every step of an instruction. Values pass from one step to the next through internal registers: the instruction register, the memory data register, the two operand registers and the ALU result register.

The block contains no sequencer. An external controller drives every select, write enable, the 2-bit ALU operation class and the two PC-update strobes on each cycle. It reads the opcode back from the block to choose the next step. An instruction takes between three and five clock cycles. The first step is a fetch that also increments the PC. The second is a decode step that reads the registers and precomputes the branch target. The steps after that depend on the instruction.

Top module: `mcdp_datapath`

## Requirements
- R1: While `rst` is high, the PC is cleared to `RESET_PC` (0 by default) and the instruction register is cleared. After reset, `pc_o` is 0, `opcode` is 0, and `mem_we` stays low while `mem_wr` is low.
- R2: With `iord`=0, `mem_addr` equals the PC. With `ir_wr`=1 the read word is captured into the instruction register, and `opcode` shows its bits [31:26]. With `pc_wr`=1, `pc_src`=0 (ALU output), `alu_src_a`=0 (PC), `alu_src_b`=1 (constant 4) and `alu_op`=0, the PC advances by 4 at the edge. With neither PC strobe set, the PC holds.
- R3: A load (opcode 35, I-format rs[25:21], rt[20:16], imm[15:0]) uses register rs plus the sign-extended imm as the address when `iord`=1. That address comes from `alu_src_a`=1, `alu_src_b`=2 and `alu_op`=0 in the step before. With `mem_to_reg`=1, `reg_dst`=0 and `reg_wr`=1, the read word is written to register rt.
- R4: A store (opcode 43) drives `mem_addr` = rs + sign-extended imm and `mem_wdata` = register rt. `mem_we` is high only in the cycle in which `mem_wr` is high.
- R5: The ALU operation is chosen as follows. `alu_op`=0 gives add. `alu_op`=1 gives subtract. `alu_op`=2 uses the funct field [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than.
- R6: Set-less-than compares as signed 32-bit numbers and gives 1 or 0.
- R7: A branch (opcode 4) uses `alu_src_b`=3 in decode, which stores PC+4 plus the sign-extended offset shifted left by 2 in the ALU result register. It then uses `alu_op`=1, `pc_wr_cond`=1 and `pc_src`=1. The PC loads the target only if rs equals rt; otherwise the PC holds PC+4.
- R8: A jump (opcode 2, with `pc_wr`=1 and `pc_src`=2) loads the PC with the upper 4 bits of PC+4, followed by the 26-bit field [25:0], followed by two zero bits.
- R9: Register 0 always reads as zero. A write to it has no effect.
- R10: A register-format operation (opcode 0, rd[15:11]) with `reg_dst`=1 writes the ALU result register to rd and leaves rt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by the ALU zero flag |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| ir_wr | input | 1 | Instruction register load |
| reg_dst | input | 1 | Write register select: 0 rt, 1 rd |
| mem_to_reg | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| reg_wr | input | 1 | Register file write enable |
| alu_src_a | input | 1 | ALU A select: 0 PC, 1 A register |
| alu_src_b | input | 2 | ALU B select: 0 B register, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_op | input | 2 | ALU operation class: 0 add, 1 subtract, 2 by funct |
| pc_src | input | 2 | PC source: 0 ALU output, 1 ALU result register, 2 jump target |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Write data to the shared memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Opcode field of the instruction register, for the controller |
| pc_o | output | 32 | Current program counter |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is in the branch execute step. There the ALU subtracts rs and rt for the equality test, and in the same cycle the PC may load the target that the ALU computed one step earlier during decode. The second pair is in fetch. There one memory read fills the instruction register, and in the same cycle the ALU advances the PC. The bench provokes both with a not-taken branch on unequal registers and a taken branch on equal ones. It also places a load directly in front of an instruction that consumes the loaded register. It judges each case from the fetch address and the PC seen at the ports, cycle by cycle, and from the words stored to memory, against an instruction-level model kept in the bench.

// File: rtl/mcdp_pkg.sv
`timescale 1ns/1ps
package mcdp_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int RIDX_W  = $clog2(REG_CNT);
    localparam int IMM_W   = 16;

    // operation codes seen by the ALU
    typedef enum logic [3:0] {
        FN_AND = 4'b0000,
        FN_OR  = 4'b0001,
        FN_ADD = 4'b0010,
        FN_SUB = 4'b0110,
        FN_SLT = 4'b0111
    } alu_fn_e;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_FUNCT = 2'b10,
        OPC_RSVD  = 2'b11
    } alu_class_e;

    typedef enum logic [1:0] {
        SB_REG   = 2'b00,
        SB_FOUR  = 2'b01,
        SB_IMM   = 2'b10,
        SB_IMMX4 = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PS_ALU    = 2'b00,
        PS_ALUREG = 2'b01,
        PS_JUMP   = 2'b10,
        PS_RSVD   = 2'b11
    } pcsel_e;

    // instruction word split into its register-format fields
    typedef struct packed {
        logic [5:0]        op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic alu_fn_e funct_to_fn(input logic [5:0] f);
        case (f)
            6'b100000: return FN_ADD;
            6'b100010: return FN_SUB;
            6'b100100: return FN_AND;
            6'b100101: return FN_OR;
            6'b101010: return FN_SLT;
            default:   return FN_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mcdp_alu_ctl.sv
`timescale 1ns/1ps
module mcdp_alu_ctl
    import mcdp_pkg::*;
(
    input  logic [1:0] alu_class,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);
    always_comb begin
        case (alu_class_e'(alu_class))
            OPC_ADD: fn = FN_ADD;
            OPC_SUB: fn = FN_SUB;
            default: fn = funct_to_fn(funct);
        endcase
    end
endmodule

// File: rtl/mcdp_alu.sv
`timescale 1ns/1ps
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SUB:  y = a - b;
            FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mcdp_regfile.sv
`timescale 1ns/1ps
module mcdp_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    logic [W-1:0] regs [NREG];

    // index 0 is never written, so it keeps its reset value of zero
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end
endmodule

// File: rtl/mcdp_datapath.sv
`timescale 1ns/1ps
module mcdp_datapath
    import mcdp_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    input  logic        iord,
    input  logic        mem_rd,
    input  logic        mem_wr,
    input  logic        ir_wr,
    input  logic        reg_dst,
    input  logic        mem_to_reg,
    input  logic        reg_wr,
    input  logic        alu_src_a,
    input  logic [1:0]  alu_src_b,
    input  logic [1:0]  alu_op,
    input  logic [1:0]  pc_src,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_re,
    output logic        mem_we,
    output logic [5:0]  opcode,
    output logic [31:0] pc_o
);
    localparam int W = XLEN;

    // step-to-step storage
    instr_t          ir_q;
    logic [W-1:0]    pc_q;
    logic [W-1:0]    mdr_q;
    logic [W-1:0]    a_q;
    logic [W-1:0]    b_q;
    logic [W-1:0]    alu_out_q;

    logic [RIDX_W-1:0]         rs_sel;
    logic [RIDX_W-1:0]         rt_sel;
    logic [RIDX_W-1:0]         wr_sel;
    logic [1:0][RIDX_W-1:0]    rf_raddr;
    logic [1:0][W-1:0]         rf_rdata;
    logic [W-1:0]              wb_data;
    logic [W-1:0]              imm_sx;
    logic [W-1:0]              op_a;
    logic [W-1:0]              op_b;
    logic [W-1:0]              alu_y;
    logic                      alu_zero;
    alu_fn_e                   alu_fn;
    logic [W-1:0]              jump_tgt;
    logic [W-1:0]              pc_next;
    logic                      pc_en;

    assign rs_sel   = ir_q.rs;
    assign rt_sel   = ir_q.rt;
    assign wr_sel   = reg_dst ? ir_q.rd : ir_q.rt;
    assign rf_raddr = {rt_sel, rs_sel};
    assign wb_data  = mem_to_reg ? mdr_q : alu_out_q;
    assign imm_sx   = sext_imm({ir_q.rd, ir_q.shamt, ir_q.funct});
    assign jump_tgt = {pc_q[W-1:W-4], ir_q.rs, ir_q.rt, ir_q.rd,
                       ir_q.shamt, ir_q.funct, 2'b00};

    mcdp_regfile #(
        .NREG (REG_CNT),
        .W    (W),
        .NRD  (2)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_wr),
        .waddr (wr_sel),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // operand selection for the shared ALU
    assign op_a = alu_src_a ? a_q : pc_q;

    always_comb begin
        case (srcb_e'(alu_src_b))
            SB_REG:   op_b = b_q;
            SB_FOUR:  op_b = W'(4);
            SB_IMM:   op_b = imm_sx;
            default:  op_b = {imm_sx[W-3:0], 2'b00};
        endcase
    end

    mcdp_alu_ctl u_actl (
        .alu_class (alu_op),
        .funct     (ir_q.funct),
        .fn        (alu_fn)
    );

    mcdp_alu #(.W(W)) u_alu (
        .a    (op_a),
        .b    (op_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // next program counter
    always_comb begin
        case (pcsel_e'(pc_src))
            PS_ALU:    pc_next = alu_y;
            PS_ALUREG: pc_next = alu_out_q;
            default:   pc_next = jump_tgt;
        endcase
    end

    assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= RESET_PC;
            ir_q      <= '0;
            mdr_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            alu_out_q <= '0;
        end else begin
            if (pc_en) pc_q <= pc_next;
            if (ir_wr) ir_q <= instr_t'(mem_rdata);
            mdr_q     <= mem_rdata;
            a_q       <= rf_rdata[0];
            b_q       <= rf_rdata[1];
            alu_out_q <= alu_y;
        end
    end

    assign mem_addr  = iord ? alu_out_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_re    = mem_rd;
    assign mem_we    = mem_wr;
    assign opcode    = ir_q.op;
    assign pc_o      = pc_q;
endmodule

// File: rtl/mcdp_checker.sv
`timescale 1ns/1ps
module mcdp_checker #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic        alu_src_a,
    input logic [1:0]  alu_src_b,
    input logic [1:0]  alu_op,
    input logic [1:0]  pc_src,
    input logic [31:0] pc,
    input logic        zero,
    input logic [4:0]  rs_sel,
    input logic [31:0] a_q
);
    // R1: reset forces the start address
    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC));

    // R2: the fetch increment adds exactly four
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b00 && !alu_src_a && alu_src_b == 2'b01 && alu_op == 2'b00)
        |=> (pc == $past(pc) + 32'd4));

    // R2: no strobe, no change
    a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !pc_wr_cond) |=> $stable(pc));

    // R7: unequal operands leave the PC in place
    a_r7_untaken_hold: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && !pc_wr && !zero) |=> $stable(pc));

    // R8: jump keeps the top nibble and word alignment
    a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10)
        |=> (pc[1:0] == 2'b00 && pc[31:28] == $past(pc[31:28])));

    // R9: reading index zero yields zero in the operand register
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (rs_sel == 5'd0) |=> (a_q == 32'd0));
endmodule

bind mcdp_datapath mcdp_checker #(.RESET_PC(RESET_PC)) u_mcdp_checker (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .alu_src_a  (alu_src_a),
    .alu_src_b  (alu_src_b),
    .alu_op     (alu_op),
    .pc_src     (pc_src),
    .pc         (pc_q),
    .zero       (alu_zero),
    .rs_sel     (rs_sel),
    .a_q        (a_q)
);

// File: tb/test_mcdp_datapath.sv
`timescale 1ns/1ps
module test_mcdp_datapath;

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr;
    logic        reg_dst, mem_to_reg, reg_wr, alu_src_a;
    logic [1:0]  alu_src_b, alu_op, pc_src;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, pc_o;
    logic        mem_re, mem_we;
    logic [5:0]  opcode;

    always #4 clk = ~clk;   // 125 MHz

    mcdp_datapath i_mcdp_datapath (
        .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .pc_src(pc_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_we(mem_we),
        .opcode(opcode), .pc_o(pc_o)
    );

    // shared memory, 64 words
    logic [31:0] mem [64];
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

    // instruction-level reference state
    logic [31:0] rf   [32];
    logic [31:0] rmem [64];
    logic [31:0] rpc;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        pc_wr = 0; pc_wr_cond = 0; iord = 0; mem_rd = 0; mem_wr = 0; ir_wr = 0;
        reg_dst = 0; mem_to_reg = 0; reg_wr = 0; alu_src_a = 0;
        alu_src_b = 2'd0; alu_op = 2'd0; pc_src = 2'd0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int word_tgt);
        return {6'd2, 26'(word_tgt)};
    endfunction

    // one instruction: controller steps plus reference update
    task automatic run_one();
        logic [31:0] ins, sx, ea, va, vb, nxt;
        int rs, rt, rd;
        ins = rmem[rpc[7:2]];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        va = rf[rs]; vb = rf[rt];
        nxt = rpc + 32'd4;
        // fetch
        idle(); mem_rd = 1; ir_wr = 1; alu_src_b = 2'd1; pc_wr = 1; #1;
        chk("R2", "fetch address", mem_addr, rpc);
        tick();
        chk("R2", "opcode", {26'd0, opcode}, {26'd0, ins[31:26]});
        chk("R2", "pc after fetch", pc_o, rpc + 32'd4);
        // decode
        idle(); alu_src_b = 2'd3; tick();
        case (opcode)
            6'd35: begin
                ea = va + sx;
                idle(); alu_src_a = 1; alu_src_b = 2'd2; tick();
                idle(); iord = 1; mem_rd = 1; #1;
                chk("R3", "load address", mem_addr, ea);
                tick();
                idle(); mem_to_reg = 1; reg_wr = 1; tick();
                if (rt != 0) rf[rt] = rmem[ea[7:2]];
            end
            6'd43: begin
                ea = va + sx;
                idle(); alu_src_a = 1; alu_src_b = 2'd2; #1;
                chk("R4", "no write before memory step", {31'd0, mem_we}, 32'd0);
                tick();
                idle(); iord = 1; mem_wr = 1; #1;
                chk("R4", "store address", mem_addr, ea);
                chk("R4", "store data", mem_wdata, vb);
                chk("R4", "write strobe", {31'd0, mem_we}, 32'd1);
                tick();
                rmem[ea[7:2]] = vb;
            end
            6'd0: begin
                logic [31:0] res;
                case (ins[5:0])
                    6'h20: res = va + vb;
                    6'h22: res = va - vb;
                    6'h24: res = va & vb;
                    6'h25: res = va | vb;
                    6'h2a: res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
                    default: res = va + vb;
                endcase
                idle(); alu_src_a = 1; alu_op = 2'd2; tick();
                idle(); reg_dst = 1; reg_wr = 1; tick();
                if (rd != 0) rf[rd] = res;
            end
            6'd4: begin
                if (va == vb) nxt = rpc + 32'd4 + {sx[29:0], 2'b00};
                idle(); alu_src_a = 1; alu_op = 2'd1; pc_wr_cond = 1; pc_src = 2'd1; tick();
                chk("R7", "branch outcome", pc_o, nxt);
            end
            6'd2: begin
                nxt = {nxt[31:28], ins[25:0], 2'b00};
                idle(); pc_wr = 1; pc_src = 2'd2; tick();
                chk("R8", "jump target", pc_o, nxt);
            end
            default: begin
                chk("R2", "known opcode", {26'd0, opcode}, 32'hFFFF_FFFF);
            end
        endcase
        chk("R2", "pc at instruction end", pc_o, nxt);
        rpc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        mem[0]  = enc_i(6'd35, 0, 1, 128);
        mem[1]  = enc_i(6'd35, 0, 2, 132);
        mem[2]  = enc_i(6'd35, 0, 10, 136);
        mem[3]  = enc_r(1, 2, 3, 6'h20);
        mem[4]  = enc_r(1, 2, 4, 6'h22);
        mem[5]  = enc_r(1, 2, 5, 6'h24);
        mem[6]  = enc_r(1, 2, 6, 6'h25);
        mem[7]  = enc_r(2, 1, 7, 6'h2a);
        mem[8]  = enc_r(1, 2, 8, 6'h2a);
        mem[9]  = enc_r(1, 1, 0, 6'h20);
        mem[10] = enc_i(6'd43, 10, 3, 0);
        mem[11] = enc_i(6'd43, 10, 4, 4);
        mem[12] = enc_i(6'd43, 10, 5, -8);
        mem[13] = enc_i(6'd43, 10, 6, -4);
        mem[14] = enc_i(6'd43, 10, 7, 8);
        mem[15] = enc_i(6'd43, 10, 8, 12);
        mem[16] = enc_i(6'd43, 10, 0, 16);
        mem[17] = enc_i(6'd43, 10, 2, 32);
        mem[18] = enc_i(6'd4, 1, 2, 3);
        mem[19] = enc_i(6'd4, 3, 3, 2);
        mem[20] = enc_i(6'd43, 10, 1, 20);
        mem[21] = enc_i(6'd43, 10, 1, 20);
        mem[22] = enc_j(25);
        mem[23] = enc_i(6'd43, 10, 1, 28);
        mem[24] = enc_i(6'd43, 10, 1, 28);
        mem[25] = enc_i(6'd35, 10, 11, 0);
        mem[26] = enc_r(11, 11, 12, 6'h20);
        mem[27] = enc_i(6'd43, 10, 12, 24);
        mem[28] = enc_i(6'd4, 12, 11, -5);
        mem[32] = 32'h0000_0007;
        mem[33] = 32'hFFFF_FFFD;
        mem[34] = 32'd160;
        for (int i = 0; i < 64; i++) rmem[i] = mem[i];
        for (int i = 0; i < 32; i++) rf[i] = 32'd0;
        rpc = 32'd0;

        idle(); rst = 1;
        repeat (3) @(posedge clk);
        #1; rst = 0; #1;
        chk("R1", "reset pc", pc_o, 32'd0);
        chk("R1", "reset opcode", {26'd0, opcode}, 32'd0);
        chk("R1", "reset write strobe", {31'd0, mem_we}, 32'd0);

        for (int k = 0; k < 25; k++) run_one();

        chk("R5", "add result", mem[40], 32'd4);
        chk("R5", "sub result", mem[41], 32'd10);
        chk("R5", "and result", mem[38], 32'd5);
        chk("R5", "or result", mem[39], 32'hFFFF_FFFF);
        chk("R6", "slt negative below positive", mem[42], 32'd1);
        chk("R6", "slt positive below negative", mem[43], 32'd0);
        chk("R9", "register zero after write", mem[44], 32'd0);
        chk("R10", "rt untouched by rd write", mem[48], 32'hFFFF_FFFD);
        chk("R7", "skipped store after taken branch", mem[45], 32'd0);
        chk("R8", "skipped store after jump", mem[47], 32'd0);
        chk("R3", "load then immediate use", mem[46], 32'd8);
        chk("R2", "final pc", pc_o, 32'd116);
        begin
            int diff = 0;
            for (int i = 0; i < 64; i++) if (mem[i] !== rmem[i]) diff++;
            chk("R4", "memory image mismatches", 32'(diff), 32'd0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule